// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary32 operands over several clock cycles. A caller presents both words, an operation select and a one-cycle `start` pulse while the unit is idle. The operands are captured on that edge. The unit then works through four phases:

- **Alignment:** the exponents are lined up one step per clock. Each step raises the smaller exponent by one and shifts its significand right by one bit.
- **Add or subtract:** the aligned significands are combined in a single cycle.
- **Normalisation:** the result is normalised one position per clock.
- **Completion:** the packed result is presented with a `done` pulse that lasts one cycle.

Words with an all-ones exponent (infinity or NaN) skip the arithmetic path and resolve in one step. The fraction is truncated, with no guard, round or sticky bits. The only flags are overflow and invalid.

The block suits datapaths where area matters more than throughput. It uses no barrel shifter or leading-zero counter. Latency depends on the data and has a fixed upper bound.

Top module: `fp_seq_adder`

## Requirements
- R1: A `start` seen while `busy` is low captures `a`, `b` and `sub`. `busy` is high from the next cycle through the cycle in which `done` is high. `done` is high for exactly one cycle, and `result` keeps its value afterwards. A `start` while `busy` is high is ignored.
- R2: Word layout: bit 31 is the sign (1 = negative), bits 30:23 are the exponent with bias 127, and bits 22:0 are the fraction. A stored exponent of 1..254 means a hidden leading 1. With `sub`=0, operands of equal sign give their sum, carrying that sign.
- R3: Exponents are equalised by raising the smaller one and shifting its significand right, truncating the bits shifted out. If the exponents differ by more than 24, the smaller operand counts as zero.
- R4: With `sub`=1 the sign of `b` is inverted. When the effective signs differ, the smaller aligned magnitude is taken from the larger, and the result carries the sign of the larger.
- R5: A carry out of the significand sum raises the exponent by one and shifts the significand right once. If the exponent would reach 255, the result is infinity with the result sign, and `ovf` is 1.
- R6: After a subtraction, the result shifts left one place per cycle, lowering the exponent, until the hidden bit is 1 or the exponent reaches its minimum. In the second case the result is subnormal, with a stored exponent of 0.
- R7: A zero significand result is always +0 (0x00000000).
- R8: A stored exponent of 0 has a hidden bit of 0 and is weighted like exponent 1 (subnormal input).
- R9: Special operands:
  - Any NaN operand gives 0x7FC00000 with `inv`=1.
  - Infinities of opposite effective sign give 0x7FC00000 with `inv`=1.
  - Otherwise, an infinite operand gives infinity with its effective sign, with `ovf`=0 and `inv`=0.
- R10: `done` rises no more than 60 cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| sub | input | 1 | 1 = a - b, 0 = a + b |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| busy | output | 1 | An operation is in progress or completing |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 32 | Packed sum or difference |
| ovf | output | 1 | Result overflowed to infinity |
| inv | output | 1 | Invalid operation, NaN returned |

## Verification
Each internal phase leaves a distinct trace at the ports:
- A wrong alignment count or a missed early exit shows up as a wrong result fraction or exponent at the next `done`.
- A normalisation loop that stops early or late shows up as an unnormalised fraction or an off-by-one exponent in that same result.
- A handshake state that gets stuck shows up within about 60 cycles: either `done` never arrives, or `done` stays high for a second cycle.

The stimulus mixes operands whose exponents sit close together with directed subnormal, overflow, cancellation and special-value cases, so that every loop exit is reached.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MAN_W  = FRAC_W + 1;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SKIP_DIFF = MAN_W;

    localparam logic [EXP_W-1:0]  EXP_ONES = '1;
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_SUM   = 3'd2,
        ST_NORM  = 3'd3,
        ST_DONE  = 3'd4
    } st_e;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
        logic             inf;
        logic             nan;
    } opnd_t;

    typedef struct packed {
        st_e               st;
        logic              sa;
        logic              sb;
        logic [EXP_W-1:0]  ea;
        logic [EXP_W-1:0]  eb;
        logic [MAN_W-1:0]  ma;
        logic [MAN_W-1:0]  mb;
        logic              rs;
        logic [EXP_W-1:0]  re;
        logic [MAN_W:0]    rm;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              inv;
    } regs_t;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic              flip,
    output opnd_t             op
);
    logic [EXP_W-1:0]  e_raw;
    logic [FRAC_W-1:0] f_raw;
    logic              e_zero;

    always_comb begin
        e_raw  = raw[WORD_W-2 -: EXP_W];
        f_raw  = raw[FRAC_W-1:0];
        e_zero = (e_raw == '0);
        op.sgn = raw[WORD_W-1] ^ flip;
        // subnormals carry weight of exponent 1 with hidden bit 0
        op.exp = e_zero ? EXP_W'(1) : e_raw;
        op.man = {~e_zero, f_raw};
        op.inf = (e_raw == EXP_ONES) && (f_raw == '0);
        op.nan = (e_raw == EXP_ONES) && (f_raw != '0);
    end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
    import fpadd_pkg::*;
(
    input  opnd_t             opa,
    input  opnd_t             opb,
    output logic              hit,
    output logic              bad,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        hit  = opa.inf | opa.nan | opb.inf | opb.nan;
        bad  = opa.nan | opb.nan | (opa.inf & opb.inf & (opa.sgn != opb.sgn));
        if (bad)
            word = QNAN_WORD;
        else if (opa.inf)
            word = {opa.sgn, EXP_ONES, {FRAC_W{1'b0}}};
        else
            word = {opb.sgn, EXP_ONES, {FRAC_W{1'b0}}};
    end
endmodule

// File: rtl/fpadd_norm_step.sv
module fpadd_norm_step
    import fpadd_pkg::*;
(
    input  logic              sgn,
    input  logic [EXP_W-1:0]  exp,
    input  logic [MAN_W:0]    man,
    output logic [EXP_W-1:0]  nxt_exp,
    output logic [MAN_W:0]    nxt_man,
    output logic              fin,
    output logic              ovf,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        nxt_exp = exp;
        nxt_man = man;
        fin     = 1'b0;
        ovf     = 1'b0;
        word    = '0;
        if (man[MAN_W]) begin
            if (exp == EXP_ONES - EXP_W'(1)) begin
                fin  = 1'b1;
                ovf  = 1'b1;
                word = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
            end else begin
                nxt_exp = exp + EXP_W'(1);
                nxt_man = man >> 1;
            end
        end else if (man == '0) begin
            fin  = 1'b1;
            word = '0;
        end else if (!man[MAN_W-1] && (exp > EXP_W'(1))) begin
            nxt_exp = exp - EXP_W'(1);
            nxt_man = man << 1;
        end else begin
            fin  = 1'b1;
            word = {sgn, (man[MAN_W-1] ? exp : {EXP_W{1'b0}}), man[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_seq_adder.sv
module fp_seq_adder
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sub,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              inv
);
    regs_t q, d;

    logic [WORD_W-1:0] raw_in [2];
    opnd_t             op_in  [2];

    assign raw_in[0] = a;
    assign raw_in[1] = b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpadd_unpack u_unpack (
            .raw  (raw_in[gi]),
            .flip ((gi == 1) ? sub : 1'b0),
            .op   (op_in[gi])
        );
    end

    logic              sp_hit, sp_bad;
    logic [WORD_W-1:0] sp_word;

    fpadd_special u_special (
        .opa  (op_in[0]),
        .opb  (op_in[1]),
        .hit  (sp_hit),
        .bad  (sp_bad),
        .word (sp_word)
    );

    logic [EXP_W-1:0]  nm_exp;
    logic [MAN_W:0]    nm_man;
    logic              nm_fin, nm_ovf;
    logic [WORD_W-1:0] nm_word;

    fpadd_norm_step u_norm (
        .sgn     (q.rs),
        .exp     (q.re),
        .man     (q.rm),
        .nxt_exp (nm_exp),
        .nxt_man (nm_man),
        .fin     (nm_fin),
        .ovf     (nm_ovf),
        .word    (nm_word)
    );

    logic [EXP_W-1:0] gap_ab, gap_ba;

    always_comb begin
        d      = q;
        gap_ab = q.ea - q.eb;
        gap_ba = q.eb - q.ea;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (sp_hit) begin
                        d.res = sp_word;
                        d.inv = sp_bad;
                        d.ovf = 1'b0;
                        d.st  = ST_DONE;
                    end else begin
                        d.sa  = op_in[0].sgn;
                        d.ea  = op_in[0].exp;
                        d.ma  = op_in[0].man;
                        d.sb  = op_in[1].sgn;
                        d.eb  = op_in[1].exp;
                        d.mb  = op_in[1].man;
                        d.ovf = 1'b0;
                        d.inv = 1'b0;
                        d.st  = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                if (q.ea == q.eb) begin
                    d.st = ST_SUM;
                end else if (q.ea < q.eb) begin
                    if (gap_ba > EXP_W'(SKIP_DIFF)) begin
                        d.ma = '0;
                        d.ea = q.eb;
                    end else begin
                        d.ma = q.ma >> 1;
                        d.ea = q.ea + EXP_W'(1);
                    end
                end else begin
                    if (gap_ab > EXP_W'(SKIP_DIFF)) begin
                        d.mb = '0;
                        d.eb = q.ea;
                    end else begin
                        d.mb = q.mb >> 1;
                        d.eb = q.eb + EXP_W'(1);
                    end
                end
            end
            ST_SUM: begin
                d.re = q.ea;
                if (q.sa == q.sb) begin
                    d.rm = {1'b0, q.ma} + {1'b0, q.mb};
                    d.rs = q.sa;
                end else if (q.ma >= q.mb) begin
                    d.rm = {1'b0, q.ma - q.mb};
                    d.rs = q.sa;
                end else begin
                    d.rm = {1'b0, q.mb - q.ma};
                    d.rs = q.sb;
                end
                d.st = ST_NORM;
            end
            ST_NORM: begin
                if (nm_fin) begin
                    d.res = nm_word;
                    d.ovf = nm_ovf;
                    d.st  = ST_DONE;
                end else begin
                    d.re = nm_exp;
                    d.rm = nm_man;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.st != ST_IDLE);
    assign done   = (q.st == ST_DONE);
    assign result = q.res;
    assign ovf    = q.ovf;
    assign inv    = q.inv;
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk
    import fpadd_pkg::*;
#(
    parameter int LAT_LIMIT = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              ovf,
    input logic              inv
);
    logic [7:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lat <= '0;
        else if (!busy) lat <= '0;
        else if (lat != 8'hFF) lat <= lat + 8'd1;
    end

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r1_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(result));
    a_r5_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (result[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));
    a_r9_inv_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inv) |-> (result == QNAN_WORD));
    a_r7_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[WORD_W-2:0] == '0)) |-> !result[WORD_W-1]);
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat < 8'(LAT_LIMIT)));
endmodule

bind fp_seq_adder fpadd_chk u_chk (.*);

// File: tb/fp_seq_adder_tb.sv
module fp_seq_adder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sub = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        busy, done, ovf, inv;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    fp_seq_adder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .a(a), .b(b),
        .busy(busy), .done(done), .result(result), .ovf(ovf), .inv(inv)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung (got %0d cycles, expected < 150000)", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // expected {ovf, inv, word} from the requirements
    function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y, input logic s);
        logic        sx, sy, rs;
        logic [7:0]  ex, ey;
        logic [22:0] fx, fy;
        logic [24:0] mx, my, m;
        int          vx, vy, e, dd;
        sx = x[31]; sy = y[31] ^ s;
        ex = x[30:23]; ey = y[30:23];
        fx = x[22:0];  fy = y[22:0];
        if ((ex == 8'hFF && fx != 0) || (ey == 8'hFF && fy != 0))
            return {2'b01, 32'h7FC00000};
        if (ex == 8'hFF && ey == 8'hFF && sx != sy)
            return {2'b01, 32'h7FC00000};
        if (ex == 8'hFF) return {2'b00, sx, 8'hFF, 23'd0};
        if (ey == 8'hFF) return {2'b00, sy, 8'hFF, 23'd0};
        mx = {1'b0, ex != 0, fx};
        my = {1'b0, ey != 0, fy};
        vx = (ex == 0) ? 1 : int'(ex);
        vy = (ey == 0) ? 1 : int'(ey);
        if (vx >= vy) begin
            dd = vx - vy; e = vx;
            my = (dd > 24) ? 25'd0 : (my >> dd);
        end else begin
            dd = vy - vx; e = vy;
            mx = (dd > 24) ? 25'd0 : (mx >> dd);
        end
        if (sx == sy)      begin m = mx + my; rs = sx; end
        else if (mx >= my) begin m = mx - my; rs = sx; end
        else               begin m = my - mx; rs = sy; end
        if (m == 0) return 34'd0;
        if (m[24]) begin
            if (e == 254) return {2'b10, rs, 8'hFF, 23'd0};
            m = m >> 1; e = e + 1;
        end
        while (!m[23] && e > 1) begin
            m = m << 1; e = e - 1;
        end
        return {2'b00, rs, (m[23] ? 8'(e) : 8'd0), m[22:0]};
    endfunction

    task automatic run_op(input logic [31:0] x, input logic [31:0] y, input logic s,
                          input logic [33:0] exp, input string req);
        int waited;
        logic [31:0] held;
        @(negedge clk);
        a = x; b = y; sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 busy after start", {33'd0, busy}, 34'd1);
        waited = 1;
        while (!done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check("R10 latency bound", {33'd0, waited <= 60}, 34'd1);
        check(req, {ovf, inv, result}, exp);
        held = result;
        @(negedge clk);
        check("R1 done single cycle / result held", {1'b0, done, result}, {2'b00, held});
    endtask

    task automatic run_rand(input logic [31:0] x, input logic [31:0] y, input logic s);
        run_op(x, y, s, model(x, y, s), "R2 R3 R4 R6 random vs model");
    endtask

    initial begin
        logic [31:0] x, y;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset state", {32'd0, busy, done}, 34'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'h3F800000, 32'h3F800000, 1'b0, {2'b00, 32'h40000000}, "R2 R5 1+1 carry");
        run_op(32'h3FC00000, 32'h3E800000, 1'b0, {2'b00, 32'h3FE00000}, "R3 1.5+0.25 align");
        run_op(32'h4C000000, 32'h3F800000, 1'b0, {2'b00, 32'h4C000000}, "R3 gap>24 skip");
        run_op(32'h3F800000, 32'h3F800000, 1'b1, {2'b00, 32'h00000000}, "R7 1-1 is +0");
        run_op(32'hBF800000, 32'h3F800000, 1'b0, {2'b00, 32'h00000000}, "R7 -1+1 is +0");
        run_op(32'h3F800000, 32'h40000000, 1'b1, {2'b00, 32'hBF800000}, "R4 1-2 sign of larger");
        run_op(32'h3F800000, 32'h3F400000, 1'b1, {2'b00, 32'h3E800000}, "R6 1-0.75 left norm");
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000}, "R5 overflow to inf");
        run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b10, 32'hFF800000}, "R5 negative overflow");
        run_op(32'h00000001, 32'h00000001, 1'b0, {2'b00, 32'h00000002}, "R8 subnormal sum");
        run_op(32'h00400000, 32'h00400000, 1'b0, {2'b00, 32'h00800000}, "R8 subnormal to normal");
        run_op(32'h00800000, 32'h00000001, 1'b1, {2'b00, 32'h007FFFFF}, "R6 result subnormal");
        run_op(32'h7FC00001, 32'h3F800000, 1'b0, {2'b01, 32'h7FC00000}, "R9 NaN input");
        run_op(32'h7F800000, 32'h7F800000, 1'b1, {2'b01, 32'h7FC00000}, "R9 inf-inf invalid");
        run_op(32'hFF800000, 32'h3F800000, 1'b0, {2'b00, 32'hFF800000}, "R9 -inf passes");
        run_op(32'h3F800000, 32'h7F800000, 1'b1, {2'b00, 32'hFF800000}, "R9 1-inf");

        // R1: start while busy is ignored
        @(negedge clk);
        a = 32'h40400000; b = 32'h3F800000; sub = 1'b0; start = 1'b1;
        @(negedge clk);
        a = 32'h7FC00000; b = 32'h7FC00000; sub = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R1 start while busy ignored", {ovf, inv, result}, {2'b00, 32'h40800000});
        @(negedge clk);

        for (int i = 0; i < 400; i++) begin
            x = $urandom();
            y = $urandom();
            if (i % 4 != 3) begin
                // keep exponents close so alignment and cancellation are exercised
                int ey;
                ey = int'(x[30:23]) + int'($urandom_range(0, 30)) - 15;
                if (ey < 0)   ey = 0;
                if (ey > 254) ey = 254;
                if (x[30:23] == 8'hFF) x[30:23] = 8'hFE;
                y[30:23] = 8'(ey);
            end
            if (i % 10 == 0) y = x ^ {1'b0, 31'($urandom_range(0, 15))};
            run_rand(x, y, 1'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule